// File: doc/BRIEF.md
# Quad-Byte Flash Program Sequencer

This block sits on the host side of a parallel flash device and writes four bytes in one operation. A requester pulses a start input while presenting a base address and a 32-bit word holding the four bytes. The block sends the quad-program command, then the four address/data write cycles. It then reads the device status byte until the device reports ready. The result is decoded and returned with a one-cycle done pulse.

Device-reported failures (bad programming voltage, program failure) and a poll timeout put the block in a locked error state. In that state new starts are refused until the requester asks for a clear, which sends the clear-status command on the bus. A suspend request seen while the device is still busy turns the outcome into a suspended result. A base address that does not sit on a four-byte boundary is rejected at once, without any bus traffic.

Top module: `qbprog_ctrl`

## Requirements
- R1: An accepted start produces one write of command byte 0x30 at the base address in the next cycle. Four writes follow in the four cycles after it. Write k (k = 0..3) goes to base+k with byte `prog_data[8k+7:8k]`.
- R2: A start in idle whose `base_addr[1:0]` is nonzero produces, one cycle later, a done pulse with result 5 (alignment error). It causes no bus cycle, and busy stays low.
- R3: After the fourth data write, the block issues plain read strobes at the base address with no command write in between. Read data is taken one cycle after each strobe. A new read follows whenever status bit 7 reads 0.
- R4: Once a read returns bit 7 = 1, the outcome is chosen in this order: suspended (3) if a suspend was seen, otherwise voltage error (1) if bit 3 is set, otherwise program error (2) if bit 4 is set, otherwise ok (0).
- R5: `suspend_req` is sampled in every polling cycle, up to and including the cycle in which the ready status is decoded. Once seen, it holds for the rest of the operation.
- R6: If `poll_limit` reads have all returned bit 7 = 0, the operation ends with result 4 (timeout) and no further read. A limit of 0 acts as 1.
- R7: Results 1, 2 and 4 raise `err_lock`. While it is high, start is ignored: there is no bus cycle, no done pulse, and busy stays low.
- R8: `clr_req` while `err_lock` is high gives one write of 0x50 at the base address in the next cycle, and then a return to idle with `err_lock` low. `clr_req` outside the error state is ignored.
- R9: Done is a single-cycle pulse. Busy is high from the cycle after an accepted start through the cycle that decodes the final status, and low while done is high. Result holds its value until the next done.
- R10: Write and read strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse for a four-byte program |
| base_addr | input | 22 | Address of byte 0, must be four-byte aligned |
| prog_data | input | 32 | Four bytes, byte 0 in bits 7:0 |
| poll_limit | input | 8 | Maximum status reads before timeout (0 acts as 1) |
| suspend_req | input | 1 | A program suspend was issued to the device |
| clr_req | input | 1 | Request to send the clear-status command |
| busy | output | 1 | Operation or clear in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 voltage, 2 program, 3 suspended, 4 timeout, 5 alignment |
| err_lock | output | 1 | Error state, waiting for a clear |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_addr | output | 22 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the cycle after a read strobe |

## Verification
The assertions rely on a few input rules. The requester pulses start only while busy is low. It keeps base address, data and poll limit stable during an operation. It raises `clr_req` only as a request and not alongside start. The device side is assumed to return a status byte exactly one cycle after each read strobe. The bench keeps within these rules: a flash-side responder answers every read from a scripted busy count and final status, and asserts suspend only during polling. All stimulus is driven on the falling edge, and a clear is issued only after done has been observed.

// File: rtl/qbprog_pkg.sv
package qbprog_pkg;

  typedef enum logic [2:0] {
    RES_OK    = 3'd0,
    RES_VPP   = 3'd1,
    RES_PROG  = 3'd2,
    RES_SUSP  = 3'd3,
    RES_TMO   = 3'd4,
    RES_ALIGN = 3'd5
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_PRD,
    ST_PWAIT,
    ST_ERR,
    ST_CLR
  } st_e;

  localparam logic [7:0] OP_PROG4 = 8'h30;
  localparam logic [7:0] OP_CLRSR = 8'h50;
  localparam int RDY_BIT = 7;
  localparam int VPP_BIT = 3;
  localparam int PGE_BIT = 4;

  // Priority decode of a ready status byte.
  function automatic res_e decode_status(input logic [7:0] sr, input logic susp);
    if (susp)              return RES_SUSP;
    else if (sr[VPP_BIT])  return RES_VPP;
    else if (sr[PGE_BIT])  return RES_PROG;
    else                   return RES_OK;
  endfunction

  function automatic logic locks(input res_e r);
    return (r == RES_VPP) || (r == RES_PROG) || (r == RES_TMO);
  endfunction

endpackage

// File: rtl/qbprog_poll_ctr.sv
module qbprog_poll_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          expired
);
  localparam logic [CW-1:0] CMAX = '1;

  function automatic logic [CW-1:0] eff_limit(input logic [CW-1:0] l);
    return (l == '0) ? CW'(1) : l;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (clear)
      count <= '0;
    else if (inc && count != CMAX)
      count <= count + CW'(1);
  end

  assign expired = (count >= eff_limit(limit));
endmodule

// File: rtl/qbprog_status_dec.sv
module qbprog_status_dec
  import qbprog_pkg::*;
(
  input  logic [7:0] sr,
  input  logic       susp,
  output logic       ready,
  output res_e       code
);
  assign ready = sr[RDY_BIT];
  assign code  = decode_status(sr, susp);
endmodule

// File: rtl/qbprog_fsm.sv
module qbprog_fsm
  import qbprog_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_ok,
  input  logic          clr_req,
  input  logic          suspend_req,
  input  logic          sr_ready,
  input  res_e          sr_code,
  input  logic          poll_expired,
  output st_e           state,
  output logic [IW-1:0] idx,
  output logic          susp_seen,
  output logic          take,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic          done,
  output res_e          result
);
  localparam logic [IW-1:0] LAST = IW'(LANES - 1);

  assign take    = (state == ST_IDLE) && start && start_ok;
  assign cnt_clr = take;
  assign cnt_inc = (state == ST_PRD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      susp_seen <= 1'b0;
      done      <= 1'b0;
      result    <= RES_OK;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (start_ok) begin
              state     <= ST_CMD;
              susp_seen <= 1'b0;
            end else begin
              done   <= 1'b1;
              result <= RES_ALIGN;
            end
          end
        end
        ST_CMD: begin
          state <= ST_DATA;
          idx   <= '0;
        end
        ST_DATA: begin
          if (idx == LAST) state <= ST_PRD;
          else             idx   <= idx + IW'(1);
        end
        ST_PRD: begin
          if (suspend_req) susp_seen <= 1'b1;
          state <= ST_PWAIT;
        end
        ST_PWAIT: begin
          if (suspend_req) susp_seen <= 1'b1;
          if (sr_ready) begin
            done   <= 1'b1;
            result <= sr_code;
            state  <= locks(sr_code) ? ST_ERR : ST_IDLE;
          end else if (poll_expired) begin
            done   <= 1'b1;
            result <= RES_TMO;
            state  <= ST_ERR;
          end else begin
            state <= ST_PRD;
          end
        end
        ST_ERR: begin
          if (clr_req) state <= ST_CLR;
        end
        ST_CLR: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qbprog_ctrl.sv
module qbprog_ctrl
  import qbprog_pkg::*;
#(
  parameter int AW    = 22,
  parameter int DW    = 8,
  parameter int LANES = 4,
  parameter int CW    = 8,
  localparam int IW   = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       base_addr,
  input  logic [LANES*DW-1:0] prog_data,
  input  logic [CW-1:0]       poll_limit,
  input  logic                suspend_req,
  input  logic                clr_req,
  output logic                busy,
  output logic                done,
  output logic [2:0]          result,
  output logic                err_lock,
  output logic                bus_wr,
  output logic                bus_rd,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_wdata,
  input  logic [DW-1:0]       bus_rdata
);
  st_e             state;
  logic [IW-1:0]   idx;
  logic            susp_seen, take, cnt_clr, cnt_inc, poll_expired;
  logic            sr_ready;
  res_e            sr_code, res_q;
  logic [CW-1:0]   poll_cnt;
  logic [AW-1:0]   base_q;
  logic [LANES*DW-1:0] data_q;
  logic [DW-1:0]   lane [LANES];

  // Named internal events for the checker.
  logic            cmd_fire, data_fire, poll_fire, clr_fire;
  logic [IW-1:0]   data_idx;

  wire start_ok = (base_addr[IW-1:0] == '0);

  qbprog_fsm #(.LANES(LANES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ok(start_ok),
    .clr_req(clr_req), .suspend_req(suspend_req),
    .sr_ready(sr_ready), .sr_code(sr_code), .poll_expired(poll_expired),
    .state(state), .idx(idx), .susp_seen(susp_seen), .take(take),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .done(done), .result(res_q)
  );

  qbprog_poll_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clr), .inc(cnt_inc),
    .limit(poll_limit), .count(poll_cnt), .expired(poll_expired)
  );

  qbprog_status_dec u_dec (
    .sr(bus_rdata), .susp(susp_seen | suspend_req),
    .ready(sr_ready), .code(sr_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      data_q <= '0;
    end else if (take) begin
      base_q <= base_addr;
      data_q <= prog_data;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = data_q[g*DW +: DW];
  end

  assign cmd_fire  = (state == ST_CMD);
  assign data_fire = (state == ST_DATA);
  assign poll_fire = (state == ST_PRD);
  assign clr_fire  = (state == ST_CLR);
  assign data_idx  = idx;

  assign bus_wr   = cmd_fire | data_fire | clr_fire;
  assign bus_rd   = poll_fire;
  assign bus_addr = {base_q[AW-1:IW], data_fire ? idx : {IW{1'b0}}};

  always_comb begin
    bus_wdata = '0;
    if (cmd_fire)       bus_wdata = OP_PROG4;
    else if (clr_fire)  bus_wdata = OP_CLRSR;
    else if (data_fire) bus_wdata = lane[idx];
  end

  assign busy     = (state != ST_IDLE) && (state != ST_ERR);
  assign err_lock = (state == ST_ERR);
  assign result   = res_q;
endmodule

// File: rtl/qbprog_chk.sv
module qbprog_chk #(
  parameter int AW = 22,
  parameter int DW = 8,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] base_addr,
  input logic          clr_req,
  input logic          busy,
  input logic          done,
  input logic [2:0]    result,
  input logic          err_lock,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          cmd_fire,
  input logic          data_fire,
  input logic [IW-1:0] data_idx
);
  localparam logic [IW-1:0] LAST = '1;

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  assert_cmd_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> bus_wr && bus_wdata == 8'h30 && bus_addr[IW-1:0] == '0);

  assert_cmd_then_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> data_fire && data_idx == '0);

  assert_data_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |-> bus_wr && bus_addr[IW-1:0] == data_idx);

  assert_data_seq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && data_idx != LAST) |=> data_fire && data_idx == $past(data_idx) + IW'(1)
      && $stable(bus_addr[AW-1:IW]));

  assert_last_to_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && data_idx == LAST) |=> bus_rd);

  assert_poll_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> bus_addr[IW-1:0] == '0 && busy);

  assert_align_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !err_lock && base_addr[IW-1:0] != '0)
      |=> done && result == 3'd5 && !bus_wr && !busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_lock_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_lock && !clr_req) |=> err_lock && !busy && !done && !bus_wr);

  assert_clr_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_lock && clr_req) |=> bus_wr && bus_wdata == 8'h50 && !err_lock);
endmodule

bind qbprog_ctrl qbprog_chk #(.AW(AW), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
  .clr_req(clr_req), .busy(busy), .done(done), .result(result),
  .err_lock(err_lock), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cmd_fire(cmd_fire),
  .data_fire(data_fire), .data_idx(data_idx)
);

// File: tb/qbprog_ctrl_tb.sv
module qbprog_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int AW = 22;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, suspend_req = 1'b0, clr_req = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [31:0] prog_data = '0;
  logic [7:0] poll_limit = 8'd8;
  logic busy, done, err_lock, bus_wr, bus_rd;
  logic [2:0] result;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata = 8'h00;

  qbprog_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .prog_data(prog_data), .poll_limit(poll_limit), .suspend_req(suspend_req),
    .clr_req(clr_req), .busy(busy), .done(done), .result(result),
    .err_lock(err_lock), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int nbusy = 0, susp_at = 0, rd_cnt = 0, wcnt = 0, rd_badaddr = 0, both_cnt = 0;
  logic [7:0] final_sr = 8'h80;
  logic [AW-1:0] exp_base = '0;
  logic [AW-1:0] wl_addr [16];
  logic [7:0]    wl_data [16];

  // Flash-side responder: status one cycle after each read strobe.
  always @(posedge clk) begin
    if (bus_wr && bus_rd) both_cnt <= both_cnt + 1;
    if (bus_wr) begin
      if (wcnt < 16) begin
        wl_addr[wcnt] <= bus_addr;
        wl_data[wcnt] <= bus_wdata;
      end
      wcnt <= wcnt + 1;
    end
    if (bus_rd) begin
      bus_rdata   <= (rd_cnt < nbusy) ? 8'h15 : (final_sr | 8'h80);
      suspend_req <= (susp_at != 0) && (rd_cnt + 1 == susp_at);
      if (bus_addr != exp_base) rd_badaddr <= rd_badaddr + 1;
      rd_cnt <= rd_cnt + 1;
    end else begin
      suspend_req <= 1'b0;
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_code(int nb, logic [7:0] fsr, int sat, int lim);
    int eff = (lim == 0) ? 1 : lim;
    if (nb >= eff) return 4;
    if (sat != 0 && sat <= nb) return 3;
    if (fsr[3]) return 1;
    if (fsr[4]) return 2;
    return 0;
  endfunction

  function automatic int exp_reads(int nb, int lim);
    int eff = (lim == 0) ? 1 : lim;
    return (nb >= eff) ? eff : nb + 1;
  endfunction

  function automatic logic exp_lock(int c);
    return (c == 1) || (c == 2) || (c == 4);
  endfunction

  task automatic clear_logs();
    wcnt = 0; rd_cnt = 0; rd_badaddr = 0;
  endtask

  task automatic run_op(input logic [AW-1:0] b, input logic [31:0] d, input int nb,
                        input logic [7:0] fsr, input int sat, input int lim);
    int code, cyc;
    bit seen, busy_at_done;
    @(negedge clk);
    clear_logs();
    nbusy = nb; final_sr = fsr; susp_at = sat; poll_limit = 8'(lim);
    exp_base = b; base_addr = b; prog_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = done; busy_at_done = busy; cyc = 0;
    while (!seen && cyc < 300) begin
      @(negedge clk);
      cyc++;
      seen = done; busy_at_done = busy;
    end
    chk(seen, "R9 done seen", seen, 1);
    chk(!busy_at_done, "R9 busy low with done", busy_at_done, 0);
    if (b[1:0] != 2'b00) begin
      chk(cyc == 0, "R2 reject latency", cyc, 0);
      chk(result == 3'd5, "R2 align result", result, 5);
      chk(wcnt == 0 && rd_cnt == 0, "R2 no bus cycle", wcnt + rd_cnt, 0);
      chk(!err_lock, "R2 no lock", err_lock, 0);
    end else begin
      code = exp_code(nb, fsr, sat, lim);
      chk(result == 3'(code), "R4/R5/R6 result", result, code);
      chk(wcnt == 5, "R1 write count", wcnt, 5);
      chk(wl_addr[0] == b && wl_data[0] == 8'h30, "R1 command write",
          {wl_addr[0], wl_data[0]}, {b, 8'h30});
      for (int k = 0; k < 4; k++)
        chk(wl_addr[k+1] == (b + AW'(k)) && wl_data[k+1] == d[8*k +: 8], "R1 data write",
            {wl_addr[k+1], wl_data[k+1]}, {b + AW'(k), d[8*k +: 8]});
      chk(rd_cnt == exp_reads(nb, lim), "R3/R6 read count", rd_cnt, exp_reads(nb, lim));
      chk(rd_badaddr == 0, "R3 read address", rd_badaddr, 0);
      chk(err_lock == exp_lock(code), "R7 lock state", err_lock, exp_lock(code));
    end
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
  endtask

  task automatic do_clear(input logic [AW-1:0] b);
    @(negedge clk);
    clear_logs();
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(wcnt == 1, "R8 clear write count", wcnt, 1);
    chk(wl_addr[0] == b && wl_data[0] == 8'h50, "R8 clear write",
        {wl_addr[0], wl_data[0]}, {b, 8'h50});
    chk(!err_lock && !busy, "R8 back to idle", {err_lock, busy}, 0);
  endtask

  task automatic try_locked_start();
    bit any_done = 0, any_busy = 0;
    @(negedge clk);
    clear_logs();
    base_addr = exp_base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      any_done |= done; any_busy |= busy;
      @(negedge clk);
    end
    chk(wcnt == 0 && rd_cnt == 0, "R7 start ignored bus", wcnt + rd_cnt, 0);
    chk(!any_done && !any_busy, "R7 start ignored done/busy", {any_done, any_busy}, 0);
    chk(err_lock, "R7 still locked", err_lock, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r_nb, r_sat, r_lim;
    logic [AW-1:0] r_b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_wr && !bus_rd && !err_lock, "R9/R10 reset state",
        {busy, done, bus_wr, bus_rd, err_lock}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(22'h001000, 32'hA1B2C3D4, 0, 8'h80, 0, 8);   // R1 R3 R4 ok immediately
    run_op(22'h3FFFFC, 32'h0102FF00, 3, 8'h80, 0, 8);   // R3 several busy reads
    run_op(22'h000040, 32'h55AA55AA, 2, 8'h98, 0, 8);   // R4 voltage before program error
    try_locked_start();                                 // R7
    do_clear(22'h000040);                               // R8
    run_op(22'h000080, 32'h12345678, 1, 8'h90, 0, 8);   // R4 program error
    do_clear(22'h000080);
    run_op(22'h000100, 32'hDEADBEEF, 4, 8'h88, 2, 8);   // R5 suspend wins over bit 3
    chk(!err_lock, "R5 suspend no lock", err_lock, 0);
    run_op(22'h000200, 32'hCAFEF00D, 10, 8'h80, 0, 3);  // R6 timeout after 3 reads
    do_clear(22'h000200);
    run_op(22'h000300, 32'h0BADC0DE, 1, 8'h80, 0, 0);   // R6 limit 0 acts as 1
    do_clear(22'h000300);
    run_op(22'h000301, 32'h11111111, 0, 8'h80, 0, 8);   // R2 misaligned
    run_op(22'h000402, 32'h22222222, 0, 8'h80, 0, 8);   // R2 misaligned
    // R8: clear request in idle is ignored
    @(negedge clk); clear_logs(); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(wcnt == 0 && !busy && !err_lock, "R8 idle clear ignored", wcnt, 0);

    for (int i = 0; i < 60; i++) begin
      r_b = AW'($urandom) & ~AW'(3);
      if ($urandom_range(7) == 0) r_b[1:0] = 2'($urandom_range(3, 1));
      r_nb  = $urandom_range(5);
      r_lim = $urandom_range(6);
      r_sat = (r_nb > 0 && $urandom_range(3) == 0) ? $urandom_range(r_nb, 1) : 0;
      run_op(r_b, $urandom, r_nb, 8'($urandom), r_sat, r_lim);
      if (err_lock) do_clear(r_b);
    end
    chk(both_cnt == 0, "R10 strobes exclusive", both_cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule